// File: doc/BRIEF.md
# Shadow-Tag Partition Stealing Replacement

This block makes the victim-partition decision for a cache whose ways are divided, per set, between a private partition and a shared partition. The line's partition is carried as a single bit: 0 means private, 1 means shared. The main tag array and the data stay outside the block. The block only decides which partition gives up a line when a fill finds its own partition full.

For every set and every partition, the block keeps a small ring of recently evicted tags, called shadow tags. It also keeps one steal flag per set and partition. A lookup that misses the cache but matches a shadow tag of its own partition sets that partition's flag. A set flag means the partition would have kept that line if it had one more way. A lookup that hits the least-recently-used line of its own partition clears the flag of the other partition in that set. A cleared flag means the line the other partition would take is still being used.

When a fill finds no free way in its own partition, the block chooses between two lines:
- the opposite partition's LRU line, when the flag of the filling partition is set;
- the filling partition's own LRU line, when that flag is clear.

A configuration input forces stealing on every full fill. The block never steals from an opposite partition that holds no lines.

Top module: `shadow_steal_repl`

## Requirements
- R1: After reset every shadow entry is invalid and every steal flag is 0. In that state, a full fill with mode 0 and a non-empty opposite partition picks its own partition.
- R2: An eviction (`ev_valid`) writes `ev_tag` into the shadow ring of partition `ev_part` in set `ev_set`. A lookup can match that entry only with the same set and the same partition.
- R3: A lookup (`lk_valid`) whose tag matches a valid shadow entry of partition `lk_part` in `lk_set` sets that set's steal flag for `lk_part`. The new flag value is visible to fills from the next cycle on.
- R4: A lookup with `lk_lru_hit`=1 clears the steal flag of partition `!lk_part` in `lk_set`. The cleared value is visible from the next cycle on.
- R5: When `fl_own_full`=0, the outputs are `vic_valid`=0, `vic_steal`=0 and `vic_part`=`fl_part`. When `fl_valid` and `fl_own_full` are both 1, `vic_valid`=1 and `vic_part` = `fl_part` XOR `vic_steal`. All outputs are combinational in the current fill inputs.
- R6: A full fill with `fl_opp_empty`=1 never steals, whatever the flag and the mode.
- R7: With `cfg_always_steal`=1, a full fill with a non-empty opposite partition always steals.
- R8: Each shadow ring holds SHADOW_DEPTH tags and overwrites the oldest first. After SHADOW_DEPTH further evictions into the same set and partition, an older tag no longer matches.
- R9: A fill of tag T into partition P of set S invalidates every shadow entry of P in S that holds T.
- R10: Steal flags and shadow rings of different sets, and of different partitions, are independent of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_always_steal | input | 1 | 1: every full fill steals from a non-empty opposite partition |
| lk_valid | input | 1 | Lookup strobe |
| lk_set | input | SET_W | Lookup set index |
| lk_part | input | 1 | Lookup partition (0 private, 1 shared) |
| lk_tag | input | TAG_W | Lookup tag |
| lk_lru_hit | input | 1 | Lookup hit the LRU line of partition lk_part |
| ev_valid | input | 1 | Eviction strobe |
| ev_set | input | SET_W | Set of the evicted line |
| ev_part | input | 1 | Partition of the evicted line |
| ev_tag | input | TAG_W | Tag of the evicted line |
| fl_valid | input | 1 | Fill strobe |
| fl_set | input | SET_W | Fill set index |
| fl_part | input | 1 | Partition of the incoming line |
| fl_tag | input | TAG_W | Tag of the incoming line |
| fl_own_full | input | 1 | Fill partition has no free way |
| fl_opp_empty | input | 1 | Opposite partition holds no lines in this set |
| vic_valid | output | 1 | A victim must be evicted |
| vic_part | output | 1 | Partition the victim is taken from |
| vic_steal | output | 1 | Victim comes from the opposite partition |

## Verification
The bench builds the block with 4 sets, 5-bit tags and a shadow depth of 4. With a ring that shallow, the oldest-first overwrite is reached after a handful of evictions. With that few sets and tags, random lookups and fills hit shadow entries often, so flags are set and cleared in every set many times. Directed sequences first cover each requirement. After that, a long random stream of lookups, evictions and fills runs in both modes. The bench computes the expected victim choice of every fill from its own model of the rings and flags.

// File: rtl/shadow_steal_repl.sv
module shadow_steal_repl #(
  parameter int NSETS        = 16,
  parameter int TAG_W        = 20,
  parameter int SHADOW_DEPTH = 8,
  localparam int SET_W = (NSETS > 1) ? $clog2(NSETS) : 1,
  localparam int PTR_W = (SHADOW_DEPTH > 1) ? $clog2(SHADOW_DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_always_steal,
  input  logic             lk_valid,
  input  logic [SET_W-1:0] lk_set,
  input  logic             lk_part,
  input  logic [TAG_W-1:0] lk_tag,
  input  logic             lk_lru_hit,
  input  logic             ev_valid,
  input  logic [SET_W-1:0] ev_set,
  input  logic             ev_part,
  input  logic [TAG_W-1:0] ev_tag,
  input  logic             fl_valid,
  input  logic [SET_W-1:0] fl_set,
  input  logic             fl_part,
  input  logic [TAG_W-1:0] fl_tag,
  input  logic             fl_own_full,
  input  logic             fl_opp_empty,
  output logic             vic_valid,
  output logic             vic_part,
  output logic             vic_steal
);

  logic [TAG_W-1:0]        sh_tag [NSETS][2][SHADOW_DEPTH];
  logic [SHADOW_DEPTH-1:0] sh_vld [NSETS][2];
  logic [PTR_W-1:0]        sh_wp  [NSETS][2];
  logic [1:0]              steal_q [NSETS];

  logic [SHADOW_DEPTH-1:0] lk_match, fl_match;
  logic                    sh_hit;
  logic [PTR_W-1:0]        ev_ptr;

  always_comb begin
    for (int i = 0; i < SHADOW_DEPTH; i++) begin
      lk_match[i] = sh_vld[lk_set][lk_part][i] && (sh_tag[lk_set][lk_part][i] == lk_tag);
      fl_match[i] = sh_vld[fl_set][fl_part][i] && (sh_tag[fl_set][fl_part][i] == fl_tag);
    end
  end

  assign sh_hit    = lk_valid & (|lk_match);
  assign ev_ptr    = sh_wp[ev_set][ev_part];
  assign vic_valid = fl_valid & fl_own_full;
  assign vic_steal = vic_valid & ~fl_opp_empty & (cfg_always_steal | steal_q[fl_set][fl_part]);
  assign vic_part  = fl_part ^ vic_steal;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NSETS; s++) begin
        steal_q[s] <= '0;
        for (int p = 0; p < 2; p++) begin
          sh_vld[s][p] <= '0;
          sh_wp[s][p]  <= '0;
        end
      end
    end else begin
      if (sh_hit)
        steal_q[lk_set][lk_part] <= 1'b1;
      if (lk_valid && lk_lru_hit)
        steal_q[lk_set][~lk_part] <= 1'b0;
      if (fl_valid)
        sh_vld[fl_set][fl_part] <= sh_vld[fl_set][fl_part] & ~fl_match;
      if (ev_valid) begin
        sh_vld[ev_set][ev_part][ev_ptr] <= 1'b1;
        sh_wp[ev_set][ev_part] <= (ev_ptr == PTR_W'(SHADOW_DEPTH - 1)) ? '0 : ev_ptr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && ev_valid)
      sh_tag[ev_set][ev_part][ev_ptr] <= ev_tag;
  end

endmodule

module shadow_steal_repl_chk #(
  parameter int SET_W = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_always_steal,
  input logic             lk_valid,
  input logic [SET_W-1:0] lk_set,
  input logic             lk_part,
  input logic             lk_lru_hit,
  input logic             sh_hit,
  input logic             fl_valid,
  input logic [SET_W-1:0] fl_set,
  input logic             fl_part,
  input logic             fl_own_full,
  input logic             fl_opp_empty,
  input logic             vic_valid,
  input logic             vic_part,
  input logic             vic_steal
);

  // R3
  a_r3_shadow_hit_steals: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sh_hit) && fl_valid && fl_own_full && !fl_opp_empty &&
     fl_set == $past(lk_set) && fl_part == $past(lk_part)) |-> vic_steal);

  // R4
  a_r4_lru_hit_blocks_steal: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lk_valid && lk_lru_hit) && fl_valid && fl_own_full && !fl_opp_empty &&
     !cfg_always_steal && fl_set == $past(lk_set) && fl_part != $past(lk_part)) |-> !vic_steal);

  // R5
  a_r5_room_no_victim: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_own_full |-> (!vic_valid && !vic_steal && vic_part == fl_part));

  // R6
  a_r6_empty_opp_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_valid && fl_opp_empty) |-> (!vic_steal && vic_part == fl_part));

  // R7
  a_r7_always_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_valid && fl_own_full && !fl_opp_empty && cfg_always_steal) |-> (vic_steal && vic_part != fl_part));

endmodule

bind shadow_steal_repl shadow_steal_repl_chk #(.SET_W(SET_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_always_steal(cfg_always_steal),
  .lk_valid(lk_valid), .lk_set(lk_set), .lk_part(lk_part), .lk_lru_hit(lk_lru_hit),
  .sh_hit(sh_hit), .fl_valid(fl_valid), .fl_set(fl_set), .fl_part(fl_part),
  .fl_own_full(fl_own_full), .fl_opp_empty(fl_opp_empty),
  .vic_valid(vic_valid), .vic_part(vic_part), .vic_steal(vic_steal));

// File: tb/tb_shadow_steal_repl.sv
module tb_shadow_steal_repl;
  localparam int PERIOD = 10;
  localparam int NS = 4;
  localparam int TW = 5;
  localparam int D  = 4;
  localparam int SW = 2;

  logic clk = 0, rst_n = 0, cfg_always_steal = 0;
  logic lk_valid = 0, lk_part = 0, lk_lru_hit = 0;
  logic [SW-1:0] lk_set = 0, ev_set = 0, fl_set = 0;
  logic [TW-1:0] lk_tag = 0, ev_tag = 0, fl_tag = 0;
  logic ev_valid = 0, ev_part = 0;
  logic fl_valid = 0, fl_part = 0, fl_own_full = 0, fl_opp_empty = 0;
  logic vic_valid, vic_part, vic_steal;

  always #(PERIOD/2) clk = ~clk;

  shadow_steal_repl #(.NSETS(NS), .TAG_W(TW), .SHADOW_DEPTH(D)) dut (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int m_tag [NS][2][D];
  bit m_vld [NS][2][D];
  int m_wp  [NS][2];
  bit m_flag[NS][2];

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    lk_valid = 0; ev_valid = 0; fl_valid = 0; lk_lru_hit = 0;
  endtask

  task automatic do_lookup(int s, int p, int t, bit lru);
    bit hit = 0;
    @(negedge clk); idle_inputs();
    lk_valid = 1; lk_set = SW'(s); lk_part = p[0]; lk_tag = TW'(t); lk_lru_hit = lru;
    for (int i = 0; i < D; i++) if (m_vld[s][p][i] && m_tag[s][p][i] == t) hit = 1;
    if (hit) m_flag[s][p] = 1;
    if (lru) m_flag[s][1-p] = 0;
  endtask

  task automatic do_evict(int s, int p, int t);
    @(negedge clk); idle_inputs();
    ev_valid = 1; ev_set = SW'(s); ev_part = p[0]; ev_tag = TW'(t);
    m_tag[s][p][m_wp[s][p]] = t; m_vld[s][p][m_wp[s][p]] = 1;
    m_wp[s][p] = (m_wp[s][p] + 1) % D;
  endtask

  task automatic do_fill(string req, int s, int p, int t, bit full, bit oempty);
    bit st; int exp;
    @(negedge clk); idle_inputs();
    fl_valid = 1; fl_set = SW'(s); fl_part = p[0]; fl_tag = TW'(t);
    fl_own_full = full; fl_opp_empty = oempty;
    #1;
    st  = full && !oempty && (cfg_always_steal || m_flag[s][p]);
    exp = {full, (p[0] ^ st), st};
    chk(req, {vic_valid, vic_part, vic_steal}, exp);
    for (int i = 0; i < D; i++) if (m_vld[s][p][i] && m_tag[s][p][i] == t) m_vld[s][p][i] = 0;
  endtask

  initial begin
    for (int s = 0; s < NS; s++)
      for (int p = 0; p < 2; p++) begin
        m_wp[s][p] = 0; m_flag[s][p] = 0;
        for (int i = 0; i < D; i++) begin m_vld[s][p][i] = 0; m_tag[s][p][i] = 0; end
      end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    for (int s = 0; s < NS; s++)
      for (int p = 0; p < 2; p++) do_fill("R1 reset no steal", s, p, 0, 1, 0);

    do_fill("R5 free way", 1, 0, 3, 0, 0);
    do_fill("R5 free way shared", 2, 1, 3, 0, 1);

    do_evict(1, 0, 5);
    do_lookup(1, 0, 5, 0);
    do_fill("R3 shadow hit steals", 1, 0, 9, 1, 0);
    do_lookup(1, 1, 5, 0);
    do_fill("R2 other partition no match", 1, 1, 9, 1, 0);
    do_fill("R10 other set unaffected", 2, 0, 9, 1, 0);

    do_lookup(1, 1, 12, 1);
    do_fill("R4 opposite lru hit clears", 1, 0, 9, 1, 0);

    do_lookup(1, 0, 5, 0);
    do_fill("R6 empty opposite kept", 1, 0, 9, 1, 1);
    do_fill("R3 flag persists", 1, 0, 9, 1, 0);

    cfg_always_steal = 1;
    do_fill("R7 always steal", 3, 1, 4, 1, 0);
    do_fill("R7 empty opposite kept", 3, 1, 4, 1, 1);
    cfg_always_steal = 0;

    for (int k = 1; k <= D + 1; k++) do_evict(0, 1, k);
    do_lookup(0, 1, 1, 0);
    do_fill("R8 oldest overwritten", 0, 1, 20, 1, 0);
    do_lookup(0, 1, 2, 0);
    do_fill("R8 kept within depth", 0, 1, 20, 1, 0);

    do_evict(2, 0, 7);
    do_fill("R9 fill back", 2, 0, 7, 0, 0);
    do_lookup(2, 0, 7, 0);
    do_fill("R9 cleared entry no steal", 2, 0, 8, 1, 0);

    for (int n = 0; n < 6000; n++) begin
      int op, s, p, t;
      if (n % 700 == 0) cfg_always_steal = (n / 700) % 3 == 2;
      op = $urandom % 3; s = $urandom % NS; p = $urandom % 2; t = $urandom % 8;
      case (op)
        0: do_lookup(s, p, t, ($urandom % 3) == 0);
        1: do_evict(s, p, t);
        default: do_fill("R5 random fill", s, p, t, ($urandom % 4) != 0, ($urandom % 4) == 0);
      endcase
    end
    @(negedge clk); idle_inputs();
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule